// File: doc/BRIEF.md
# Eight-Line Interrupt Mask and Command Decoder

This block is the core of a small programmable interrupt controller for eight request lines. It brings each asynchronous request line into the clock domain, catches its rising edge in a request register, and filters pending requests through a software-written mask. A fixed-priority picker finds the most urgent unmasked request. It asserts the interrupt output only when that request ranks above everything already in service.

Software reaches the block through a one-bit register address. A write at the odd address always loads the mask. A write at the even address carries a command word, and data bits 4 and 3 decide which kind it is. One kind ends service for a level, either the most urgent level in service or a level named in the word. The other kind is a special-mode word, which this core accepts and discards. A CPU acknowledge strobe moves the winning request into service and reports its 3-bit index for one cycle.

Top module: `irq_mask_core`

## Requirements
- R1: After reset the mask, request and in-service registers are all zero. `irq_out`, `vec_valid` and `rd_data` are low, and a read of the mask returns 0.
- R2: A write with `addr`=1 loads `wr_data` into the 8-bit mask, whatever values bits 4 and 3 hold. A read strobe with `addr`=1 returns the mask on `rd_data` after the next clock edge. A read with `addr`=0 returns 0.
- R3: A rising level on `irq_in[n]` is latched once into request bit n. If the rising level is present at clock edge k, the bit is set at edge k+2, and `irq_out` reflects it after edge k+3. A level held high is not latched again.
- R4: Mask bit n set to 1 blocks line n from `irq_out`, but the line still latches its request. When the mask bit is later cleared to 0, `irq_out` rises after the next clock edge.
- R5: Priority is fixed, with line 0 the most urgent. `irq_out` is high in the cycle after some unmasked pending line has a lower index than every in-service bit, and is low otherwise.
- R6: An `inta` pulse while such a line exists clears that request bit and sets its in-service bit. It also drives `vec_valid` high for one cycle with `vec_idx` equal to the line index. An `inta` pulse with no eligible line changes nothing.
- R7: An even-address write with bits [4:3]=00 and code bits [7:5]=001 clears the lowest-numbered set in-service bit.
- R8: An even-address write with bits [4:3]=00 and code bits [7:5]=011 clears the in-service bit named by bits [2:0].
- R9: Even-address writes with any other code are ignored, as are writes with bits [4:3]=01 (special mode) and writes with bit 4=1. They leave the mask, request and in-service state unchanged.
- R10: When an acknowledge and an end-of-service command fall in the same cycle, the command acts on the in-service state as it was before that cycle, and the acknowledged bit is still set. When a new rising edge on a line meets an acknowledge of the same line, the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address bit |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 8 | Asynchronous request lines |
| inta | input | 1 | CPU acknowledge strobe |
| irq_out | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | One-cycle flag that `vec_idx` holds the acknowledged line |
| vec_idx | output | 3 | Index of the acknowledged line |

## Verification
Two kinds of collision can happen in a single cycle. An acknowledge can arrive together with an end-of-service write. A freshly detected request edge can also land on the very line being acknowledged. The bench stages both on purpose. For the first, it puts a low-priority line in service, raises a more urgent one, and sends the acknowledge and a non-specific end-of-service together. For the second, it drops a pending line and raises it again so that the edge matures in the acknowledge cycle. The results are judged through the acknowledged index and through the later behaviour of `irq_out`. A long mixed run, driven by a shift-register sequence and checked against an arithmetic model, hits both collisions many more times.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Kind of register write seen on the port
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_MASK    = 2'd1,
    CMD_PRIO    = 2'd2,
    CMD_SPECIAL = 2'd3
  } cmd_kind_e;

  // Code field values of the priority command word (bits [7:5])
  localparam logic [2:0] OP_EOI_TOP = 3'b001;
  localparam logic [2:0] OP_EOI_LVL = 3'b011;

  typedef struct packed {
    cmd_kind_e  kind;
    logic [2:0] op;
    logic [2:0] level;
  } cmd_t;

endpackage

// File: rtl/irqc_cmd_decode.sv
module irqc_cmd_decode
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_t              cmd
);

  // Field positions are fixed by the command word layout
  localparam int SEL_HI = 4;
  localparam int SEL_LO = 3;

  always_comb begin
    cmd.op    = wr_data[7:5];
    cmd.level = wr_data[2:0];
    if (!wr_en) begin
      cmd.kind = CMD_NONE;
    end else if (addr) begin
      cmd.kind = CMD_MASK;
    end else if (wr_data[SEL_HI]) begin
      cmd.kind = CMD_NONE;
    end else if (wr_data[SEL_LO]) begin
      cmd.kind = CMD_SPECIAL;
    end else begin
      cmd.kind = CMD_PRIO;
    end
  end

endmodule

// File: rtl/irqc_req_sync.sv
module irqc_req_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] rise
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q;
    logic s2_q;
    logic prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= irq_in[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign rise[g] = s2_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]); // R3
  end

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest index wins
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_mask_core.sv
module irq_mask_core
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic                          addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [NUM_LINES-1:0]          irq_in,
  input  logic                          inta,
  output logic                          irq_out,
  output logic                          vec_valid,
  output logic [$clog2(NUM_LINES)-1:0]  vec_idx
);

  localparam int IDX_W = $clog2(NUM_LINES);

  function automatic logic [NUM_LINES-1:0] bit_at(input logic [IDX_W-1:0] i);
    bit_at    = '0;
    bit_at[i] = 1'b1;
  endfunction

  cmd_t                 cmd;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] imr;
  logic [NUM_LINES-1:0] irr;
  logic [NUM_LINES-1:0] isr;
  logic [NUM_LINES-1:0] pend;
  logic                 pend_any;
  logic [IDX_W-1:0]     pend_idx;
  logic                 serv_any;
  logic [IDX_W-1:0]     serv_idx;
  logic                 eligible;
  logic                 take;
  logic                 mask_we;
  logic                 eoi_top;
  logic                 eoi_lvl;
  logic [NUM_LINES-1:0] ack_bits;
  logic [NUM_LINES-1:0] eoi_bits;

  irqc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  irqc_req_sync #(.N(NUM_LINES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .rise   (rise)
  );

  assign pend = irr & ~imr;

  irqc_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick_pend (
    .vec (pend),
    .any (pend_any),
    .idx (pend_idx)
  );

  irqc_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick_serv (
    .vec (isr),
    .any (serv_any),
    .idx (serv_idx)
  );

  assign mask_we  = (cmd.kind == CMD_MASK);
  assign eoi_top  = (cmd.kind == CMD_PRIO) && (cmd.op == OP_EOI_TOP);
  assign eoi_lvl  = (cmd.kind == CMD_PRIO) && (cmd.op == OP_EOI_LVL);
  assign eligible = pend_any && (!serv_any || (pend_idx < serv_idx));
  assign take     = inta && eligible;
  assign ack_bits = take ? bit_at(pend_idx) : '0;

  always_comb begin
    eoi_bits = '0;
    if (eoi_top && serv_any) eoi_bits = bit_at(serv_idx);
    else if (eoi_lvl)        eoi_bits = bit_at(IDX_W'(cmd.level));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr       <= '0;
      irr       <= '0;
      isr       <= '0;
      irq_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      rd_data   <= '0;
    end else begin
      if (mask_we) imr <= wr_data[NUM_LINES-1:0];
      irr       <= (irr & ~ack_bits) | rise;
      isr       <= (isr & ~eoi_bits) | ack_bits;
      irq_out   <= eligible;
      vec_valid <= take;
      if (take) vec_idx <= pend_idx;
      rd_data   <= (rd_en && addr) ? DATA_W'(imr) : '0;
    end
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (imr == $past(wr_data[NUM_LINES-1:0]))); // R2
  AST_RD_EVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> (rd_data == '0)); // R2
  AST_IRR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !inta |=> ((irr & $past(irr)) == $past(irr))); // R4
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(pend_any)); // R5
  AST_VEC_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta)); // R6
  AST_VEC_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> isr[vec_idx]); // R6
  AST_ISR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(eoi_top || eoi_lvl) |=> ((isr & $past(isr)) == $past(isr))); // R9

endmodule

// File: tb/tb_irq_mask_core.sv
module tb_irq_mask_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] irq_in = '0;
  logic [7:0] rd_data;
  logic       irq_out, vec_valid;
  logic [2:0] vec_idx;

  always #4 clk = ~clk;

  irq_mask_core dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in), .inta(inta),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_idx(vec_idx)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] lvl = '0;

  // Arithmetic model of the requirements
  logic [7:0] m_imr = '0, m_irr = '0, m_isr = '0;
  logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_rd = '0;
  logic       m_irq = 1'b0, m_vv = 1'b0;
  logic [2:0] m_vi = '0;

  function automatic int low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic a, input logic [7:0] d,
                     input logic r, input logic k, input string tag);
    logic [7:0] edge_b, pend, ackb, eoib;
    int wn, tp;
    logic elig;
    wr_en = w; addr = a; wr_data = d; rd_en = r; inta = k; irq_in = lvl;
    edge_b = m_s2 & ~m_prev;
    pend   = m_irr & ~m_imr;
    wn     = low(pend);
    tp     = low(m_isr);
    elig   = (pend != 0) && (wn < tp);
    ackb   = '0;
    if (k && elig) ackb[wn] = 1'b1;
    eoib = '0;
    if (w && !a && d[4:3] == 2'b00) begin
      if (d[7:5] == 3'b001 && tp < 8) eoib[tp] = 1'b1;
      else if (d[7:5] == 3'b011)      eoib[d[2:0]] = 1'b1;
    end
    @(posedge clk);
    m_rd   = (r && a) ? m_imr : 8'h00;
    if (w && a) m_imr = d;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = lvl;
    m_irr  = (m_irr & ~ackb) | edge_b;
    m_isr  = (m_isr & ~eoib) | ackb;
    m_irq  = elig;
    m_vv   = k && elig;
    if (m_vv) m_vi = 3'(wn);
    @(negedge clk);
    chk(tag, "irq_out", 32'(irq_out), 32'(m_irq));
    chk(tag, "vec_valid", 32'(vec_valid), 32'(m_vv));
    if (m_vv) chk(tag, "vec_idx", 32'(vec_idx), 32'(m_vi));
    chk(tag, "rd_data", 32'(rd_data), 32'(m_rd));
    wr_en = 1'b0; rd_en = 1'b0; inta = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask
  task automatic wr(input logic a, input logic [7:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, 1'b0, tag);
  endtask
  task automatic rd(input logic a, input string tag);
    cyc(1'b0, a, 8'h00, 1'b1, 1'b0, tag);
  endtask
  task automatic ack(input string tag);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [7:0]  mk;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", "irq_out", 32'(irq_out), 0);
    chk("R1", "vec_valid", 32'(vec_valid), 0);
    rd(1'b1, "R1");
    chk("R1", "mask read", 32'(rd_data), 0);

    // R2: mask load and readback
    wr(1'b1, 8'hA5, "R2");
    rd(1'b1, "R2");
    chk("R2", "mask A5", 32'(rd_data), 32'h A5);
    rd(1'b0, "R2");
    chk("R2", "even read", 32'(rd_data), 0);
    wr(1'b1, 8'h18, "R2");
    rd(1'b1, "R2");
    chk("R2", "mask 18", 32'(rd_data), 32'h18);
    wr(1'b1, 8'h00, "R2");

    // R3: edge latch timing, no relatch on held level
    lvl = 8'h04;
    idle(3, "R3");
    chk("R3", "irq before k+3", 32'(irq_out), 0);
    idle(1, "R3");
    chk("R3", "irq at k+3", 32'(irq_out), 1);
    ack("R3");
    chk("R3", "vec_idx", 32'(vec_idx), 2);
    wr(1'b0, 8'h20, "R3");
    idle(4, "R3");
    chk("R3", "held level no relatch", 32'(irq_out), 0);
    lvl = 8'h00;
    idle(3, "R3");

    // R4: masked line latches and fires on unmask
    wr(1'b1, 8'h10, "R4");
    lvl = 8'h10;
    idle(6, "R4");
    chk("R4", "masked irq", 32'(irq_out), 0);
    wr(1'b1, 8'h00, "R4");
    idle(1, "R4");
    chk("R4", "unmasked irq", 32'(irq_out), 1);
    ack("R4");
    wr(1'b0, 8'h20, "R4");
    lvl = 8'h00;
    idle(3, "R4");

    // R6: acknowledge with nothing eligible
    ack("R6");
    chk("R6", "idle ack vec_valid", 32'(vec_valid), 0);

    // R7 / R8: nested service then end-of-service commands
    lvl = 8'h20; idle(4, "R7"); ack("R7");
    lvl = 8'h28; idle(4, "R7"); ack("R7");
    lvl = 8'h2A; idle(4, "R7"); ack("R7");
    chk("R7", "vec_idx 1", 32'(vec_idx), 1);
    wr(1'b0, 8'h63, "R8");
    lvl = 8'h3A; idle(4, "R8");
    chk("R8", "line4 blocked by 1", 32'(irq_out), 0);
    wr(1'b0, 8'h20, "R7");
    idle(1, "R7");
    chk("R8", "line4 ranks above 5 once 3 and 1 cleared", 32'(irq_out), 1);
    ack("R7");
    chk("R7", "vec_idx 4", 32'(vec_idx), 4);
    repeat (3) wr(1'b0, 8'h20, "R7");
    lvl = 8'h00; idle(3, "R7");

    // R9: ignored command words
    lvl = 8'h40; idle(4, "R9"); ack("R9");
    lvl = 8'hC0; idle(4, "R9");
    wr(1'b0, 8'h28, "R9");
    wr(1'b0, 8'h30, "R9");
    wr(1'b0, 8'hA0, "R9");
    wr(1'b0, 8'h40, "R9");
    idle(1, "R9");
    chk("R9", "service kept", 32'(irq_out), 0);
    rd(1'b1, "R9");
    chk("R9", "mask kept", 32'(rd_data), 0);
    wr(1'b0, 8'h20, "R9");
    idle(1, "R9");
    chk("R9", "real EOI frees line7", 32'(irq_out), 1);
    ack("R9"); wr(1'b0, 8'h20, "R9");
    lvl = 8'h00; idle(3, "R9");

    // R10: acknowledge together with end-of-service
    lvl = 8'h04; idle(4, "R10"); ack("R10");
    lvl = 8'h05; idle(4, "R10");
    cyc(1'b1, 1'b0, 8'h20, 1'b0, 1'b1, "R10");
    chk("R10", "ack+EOI vec_idx", 32'(vec_idx), 0);
    wr(1'b0, 8'h20, "R10");
    idle(1, "R10");
    chk("R10", "no pending left", 32'(irq_out), 0);
    // R10: fresh edge meets acknowledge of same line
    lvl = 8'h00; idle(3, "R10");
    lvl = 8'h08; idle(4, "R10");
    lvl = 8'h00; idle(2, "R10");
    lvl = 8'h08; idle(2, "R10");
    ack("R10");
    chk("R10", "edge+ack vec_idx", 32'(vec_idx), 3);
    wr(1'b0, 8'h20, "R10");
    idle(1, "R10");
    chk("R10", "request kept", 32'(irq_out), 1);
    ack("R10"); wr(1'b0, 8'h20, "R10");
    lvl = 8'h00; idle(3, "R10");

    // R5: sweep of request patterns against varied masks
    for (int p = 1; p < 256; p++) begin
      mk  = 8'(p * 37 + 11);
      lvl = 8'(p);
      idle(3, "R5");
      wr(1'b1, mk, "R5");
      idle(2, "R5");
      for (int j = 0; j < 9; j++) begin ack("R5"); wr(1'b0, 8'h20, "R5"); end
      wr(1'b1, 8'h00, "R5");
      idle(2, "R5");
      for (int j = 0; j < 9; j++) begin ack("R5"); wr(1'b0, 8'h20, "R5"); end
      lvl = 8'h00;
      idle(3, "R5");
    end

    // R10: mixed traffic from a shift-register sequence
    lf = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      logic w, a, k, r;
      logic [7:0] d;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) lvl = lvl ^ (8'h01 << lf[5:3]);
      w = 1'b1; a = 1'b0; d = 8'h00;
      case (lf[8:6])
        3'd0: begin a = 1'b1; d = lf[15:8]; end
        3'd1: d = 8'h20;
        3'd2: d = {5'b01100, lf[11:9]};
        3'd3: d = {lf[15:13], 2'b01, lf[11:9]};
        3'd4: d = {lf[15:13], 2'b10, lf[11:9]};
        default: begin w = 1'b0; a = lf[15]; end
      endcase
      k = lf[12] | lf[13];
      r = lf[14];
      cyc(w, a, d, r, k, "R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule